// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets each of N processor cores interrupt any other core and hand it a 16-bit message. Every core owns a pair of 32-bit words in a small register window: a command word that the core writes to act, and a mailbox word that records the last message delivered to it. Each core also has one level interrupt line. The interrupt line stays high while that core's mailbox holds an unacknowledged message.

A core sends a message by writing its own command word with the send bit set, a target core number and a payload. The target's mailbox is overwritten with a pending flag, the sender's number and the payload. Its interrupt line rises on the next clock edge. The receiver clears the message by writing the acknowledge bit into its own command word. The mailbox has one slot per core, so a later send replaces an earlier one. The register port is a plain single-cycle slave port. Writes take effect at the clock edge on which the write strobe is high. Read data is combinational on the address and reflects the state after the last edge. There is no read strobe and no back-pressure: every access completes in the cycle it is presented.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every command word and mailbox word reads zero and every interrupt output is low.
- R2: A write to the command word of core i (byte address i*8, address bit 2 = 0) stores all 32 written bits, and a read of that address returns them.
- R3: A command write with bit 30 set and a target number t in bits 29:16 (t below the core count) replaces the mailbox of core t. The new mailbox has the pending flag (bit 30) set, the writer's index in bits 29:16 and written bits 15:0 in bits 15:0. Interrupt output t is high from the next clock edge.
- R4: A command write with bit 31 set clears the writer's own pending flag and drops its interrupt output at the next edge. The sender and payload fields keep their values.
- R5: When one write sets both bit 30 and bit 31, the send is applied first and the acknowledge second. A core that sends to itself this way ends with pending clear. A send to another core in the same write still arrives there.
- R6: Writes to a mailbox word (address bit 2 = 1) change no state.
- R7: An address whose core index (address bits from 3 up) is at or above the core count ignores writes and reads zero.
- R8: A send whose target number is at or above the core count changes no mailbox and no interrupt output. The command word is still stored.
- R9: A mailbox read returns zero in bit 31 and in every unused bit. Its bit 30 always equals that core's interrupt output.
- R10: A second send to a core replaces the sender and payload of the first, whether or not the first was acknowledged.
- R11: Reads are combinational on the address. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address into the register window |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | N | Per-core level interrupt outputs |

## Verification
The bench runs with three cores in a window sized for four. This leaves index 3 as a real out-of-range address and as an out-of-range target. A design that decoded modulo the window would then corrupt a live core.

The bench sends two messages to one core without an acknowledge in between. A design that merged or kept the older message would show the wrong sender or payload.

The bench combines send and acknowledge in one write, both to self and to another core. A wrong ordering would leave a self-sent interrupt stuck high, or would drop the remote delivery.

The bench writes to a mailbox word and reads through nonzero low address bits. A design that let software set pending, or that decoded bits 1:0, would fail at once.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W    = 32;
  localparam int CMD_ACK   = 31;
  localparam int CMD_SEND  = 30;
  localparam int ID_LSB    = 16;
  localparam int ID_W      = 14;
  localparam int PAY_W     = 16;
  localparam int PEND_BIT  = 30;

  // Assemble a mailbox word from its fields; unused bits are zero.
  function automatic logic [WORD_W-1:0] mbox_word(input logic pend,
                                                  input logic [ID_W-1:0] src,
                                                  input logic [PAY_W-1:0] pay);
    return {1'b0, pend, src, pay};
  endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec #(
  parameter int N      = 1,
  parameter int ADDR_W = 5,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:2] addr_hi,
  input  logic              we,
  input  logic [31:16]      cmd_hi,
  output logic [N-1:0]      ctrl_we,
  output logic [N-1:0]      send_hit,
  output logic [N-1:0]      ack_hit,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok,
  output logic              sel_mbox
);
  logic [13:0] dest;
  logic        dest_ok;
  logic        cmd_wr;

  assign idx      = addr_hi[ADDR_W-1:3];
  assign sel_mbox = addr_hi[2];
  assign idx_ok   = int'(idx) < N;
  assign dest     = cmd_hi[29:16];
  assign dest_ok  = int'(dest) < N;
  assign cmd_wr   = we && !sel_mbox && idx_ok;

  for (genvar k = 0; k < N; k++) begin : g_hit
    assign ctrl_we[k]  = cmd_wr && (int'(idx) == k);
    assign ack_hit[k]  = ctrl_we[k] && cmd_hi[31];
    assign send_hit[k] = cmd_wr && cmd_hi[30] && dest_ok && (int'(dest) == k);
  end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [31:0]      wdata,
  input  logic             send_hit,
  input  logic [IDX_W-1:0] send_src,
  input  logic             ack_hit,
  output logic [31:0]      ctrl_word,
  output logic [31:0]      mbox_word,
  output logic             irq
);
  import ipi_pkg::*;

  logic [31:0]      ctrl_q;
  logic             pend_q;
  logic [IDX_W-1:0] src_q;
  logic [PAY_W-1:0] pay_q;
  logic             pend_n;

  // send first, acknowledge second
  always_comb begin
    pend_n = pend_q;
    if (send_hit) pend_n = 1'b1;
    if (ack_hit)  pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      src_q  <= '0;
      pay_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (send_hit) begin
        src_q <= send_src;
        pay_q <= wdata[PAY_W-1:0];
      end
      pend_q <= pend_n;
      irq    <= pend_n;
    end
  end

  assign ctrl_word = ctrl_q;
  assign mbox_word = ipi_pkg::mbox_word(pend_q, ID_W'(src_q), pay_q);
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux #(
  parameter int N     = 1,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][31:0] ctrl_words,
  input  logic [N-1:0][31:0] mbox_words,
  input  logic [IDX_W-1:0]   idx,
  input  logic               idx_ok,
  input  logic               sel_mbox,
  output logic [31:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < N; k++) begin
      if (idx_ok && int'(idx) == k)
        rdata = sel_mbox ? mbox_words[k] : ctrl_words[k];
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int N      = 1,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N-1:0]      irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic [N-1:0]        ctrl_we, send_hit, ack_hit;
  logic [IDX_W-1:0]    idx;
  logic                idx_ok, sel_mbox;
  logic [N-1:0][31:0]  ctrl_words, mbox_words;
  logic                unused_lo;

  assign unused_lo = ^bus_addr[1:0];

  ipi_addr_dec #(.N(N), .ADDR_W(ADDR_W)) u_dec (
    .addr_hi (bus_addr[ADDR_W-1:2]),
    .we      (bus_we),
    .cmd_hi  (bus_wdata[31:16]),
    .ctrl_we (ctrl_we),
    .send_hit(send_hit),
    .ack_hit (ack_hit),
    .idx     (idx),
    .idx_ok  (idx_ok),
    .sel_mbox(sel_mbox)
  );

  for (genvar k = 0; k < N; k++) begin : g_core
    ipi_core_slot #(.IDX_W(IDX_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we[k]),
      .wdata    (bus_wdata),
      .send_hit (send_hit[k]),
      .send_src (idx),
      .ack_hit  (ack_hit[k]),
      .ctrl_word(ctrl_words[k]),
      .mbox_word(mbox_words[k]),
      .irq      (irq[k])
    );
  end

  ipi_rd_mux #(.N(N), .IDX_W(IDX_W)) u_rd (
    .ctrl_words(ctrl_words),
    .mbox_words(mbox_words),
    .idx       (idx),
    .idx_ok    (idx_ok),
    .sel_mbox  (sel_mbox),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int N      = 1,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [N-1:0]      irq
);
  localparam int IDX_W = ADDR_W - 3;
  logic [IDX_W-1:0] a_idx;
  logic             a_ok, a_mbox, cmd_wr;
  assign a_idx  = bus_addr[ADDR_W-1:3];
  assign a_ok   = int'(a_idx) < N;
  assign a_mbox = bus_addr[2];
  assign cmd_wr = bus_we && !a_mbox && a_ok;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> irq == '0);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(irq));

  // R7
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ok |-> bus_rdata == 32'h0);

  for (genvar k = 0; k < N; k++) begin : g_k
    // R3
    send_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[30] && int'(bus_wdata[29:16]) == k &&
       !(bus_wdata[31] && int'(a_idx) == k)) |=> irq[k]);
    // R4
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[31] && int'(a_idx) == k) |=> !irq[k]);
    // R9
    pend_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_mbox && int'(a_idx) == k) |-> (!bus_rdata[31] && bus_rdata[30] == irq[k]));
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/tb_ipi_mailbox.sv
module tb_ipi_mailbox;
  localparam int N = 3;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq;

  always #2 clk = ~clk;

  ipi_mailbox #(.N(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit probe = 1'b0, done = 1'b0;

  // monitor: pops one expectation per probed cycle
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? 32'(irq) : bus_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] adr(int core, int mbox, int lo);
    return AW'(core * 8 + mbox * 4 + lo);
  endfunction

  task automatic wr(int core, int mbox, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = adr(core, mbox, 0); bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(int core, int mbox, int lo, logic [31:0] e, string tag);
    @(posedge clk); #1;
    bus_addr = adr(core, mbox, lo);
    q.push_back('{1'b0, e, tag});
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic ck_irq(logic [N-1:0] e, string tag);
    @(posedge clk); #1;
    q.push_back('{1'b1, 32'(e), tag});
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, 0, 32'h0, "R1 ctrl0");
    rd(0, 1, 0, 32'h0, "R1 mbox0");
    rd(2, 1, 0, 32'h0, "R1 mbox2");
    ck_irq(3'b000, "R1 irq");
    // R2 R3 send 0 -> 2
    wr(0, 0, 32'h4002_ABCD);
    rd(0, 0, 0, 32'h4002_ABCD, "R2 ctrl0 readback");
    rd(2, 1, 0, 32'h4000_ABCD, "R3 mbox2");
    ck_irq(3'b100, "R3 irq2 high");
    // R10 overwrite from core 1
    wr(1, 0, 32'h4002_1234);
    rd(2, 1, 0, 32'h4001_1234, "R10 mbox2 replaced");
    // R6 mailbox write ignored
    wr(2, 1, 32'h0000_0000);
    rd(2, 1, 0, 32'h4001_1234, "R6 mbox2 kept");
    ck_irq(3'b100, "R6 irq kept");
    // R4 acknowledge
    wr(2, 0, 32'h8000_0000);
    rd(2, 1, 0, 32'h0001_1234, "R4 mbox2 fields kept");
    ck_irq(3'b000, "R4 irq2 low");
    // R5 self send plus ack
    wr(1, 0, 32'hC001_5555);
    rd(1, 1, 0, 32'h0001_5555, "R5 self cleared");
    ck_irq(3'b000, "R5 self irq low");
    // R5 remote send plus own ack
    wr(2, 0, 32'hC000_7777);
    rd(0, 1, 0, 32'h4002_7777, "R5 remote delivered");
    rd(2, 1, 0, 32'h0001_1234, "R5 own kept cleared");
    ck_irq(3'b001, "R5 irq0 high");
    // R8 target out of range
    wr(0, 0, 32'h4003_1111);
    rd(0, 0, 0, 32'h4003_1111, "R8 ctrl stored");
    rd(0, 1, 0, 32'h4002_7777, "R8 mbox0 unchanged");
    wr(1, 0, 32'h7FFF_0001);
    ck_irq(3'b001, "R8 irq unchanged");
    // R7 core index out of range
    wr(3, 0, 32'h4000_9999);
    rd(3, 0, 0, 32'h0, "R7 oor ctrl zero");
    rd(3, 1, 0, 32'h0, "R7 oor mbox zero");
    rd(0, 1, 0, 32'h4002_7777, "R7 mbox0 unchanged");
    // R11 low address bits ignored, R9 bit 31 zero
    rd(0, 1, 3, 32'h4002_7777, "R11 low bits");
    rd(1, 0, 2, 32'h7FFF_0001, "R11 ctrl1 low bits");
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 1, 0, 32'h0002_7777, "R9 mbox0 bit31 zero");
    ck_irq(3'b000, "R9 irq follows pending");
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule